// File: doc/BRIEF.md
# Load/Store Byte-Lane Formatter

This block sits between a 64-bit register datapath and a cache port that moves whole doublewords. On the store side it takes a register value, an address offset inside the doubleword, an access size and a byte-reverse flag. It returns the value arranged in memory byte lanes, plus a byte-enable mask for the first doubleword and a second mask for the doubleword that follows. Each output lane is picked from one register byte by a single selection step, so byte reversal and alignment cost one multiplexer level. The data is rotated rather than shifted. Bytes that spill past the top lane therefore already sit in the low lanes, and the same data word can be sent with the second request of a boundary-crossing store.

On the load side it accepts returned doublewords one beat at a time. An access that stays inside one doubleword completes on its first beat. An access that crosses into the next doubleword takes two beats. The block keeps the first beat and control, merges the second beat into the lanes that spilled over, and only then produces the register value. The value is brought back into register byte order, optionally byte-reversed, and sign- or zero-extended to 64 bits.

Both paths use valid/ready handshakes with one output register each. An input beat is accepted in a cycle where `*_in_valid` and `*_in_ready` are both high. An input is ready exactly when its output register is empty or is being drained in the same cycle. A held output keeps its value until `*_out_ready` is seen high. Results appear on the clock edge that accepts the completing beat.

Top module: `lsf_top`

## Requirements
- R1: Store with reverse flag low: size code s (0,1,2,3 meaning n = 1,2,4,8 bytes) and offset o. Output lane L (bits 8L+7:8L) carries register byte (L-o) mod 8 for every lane, so lane (o+k) mod 8 holds register byte k.
- R2: Store with reverse flag high: output lane L carries register byte (n-1-((L-o) mod 8)) mod 8, so lane (o+k) mod 8 holds register byte n-1-k for k < n.
- R3: Store masks: the 16-bit value ((2^n)-1) shifted left by o gives the first-doubleword enables in bits 7:0 and the second-doubleword enables in bits 15:8. The crossing flag is high exactly when the second mask is nonzero.
- R4: A load that does not cross (o+n <= 8) completes on one beat. Register byte k (k < n) is lane (o+k) mod 8 with reverse low, and lane (o+n-1-k) mod 8 with reverse high.
- R5: Load extension: register bytes k >= n are all zero when the sign flag is low. When it is high they are copies of bit 7 of register byte n-1, taken after reversal. An 8-byte load is unaffected by the flag.
- R6: A crossing load (o+n > 8) produces no result on its first beat. Its result comes with the second beat: lanes set in the second mask come from the second beat, and all other lanes come from the first. Offset, size, reverse and sign inputs on the second beat are ignored. Extension is applied after the merge.
- R7: Store handshake: `st_in_ready` equals (not `st_out_valid`) or `st_out_ready`. A stalled store output holds its data and masks unchanged.
- R8: Load handshake: `ld_in_ready` equals (not `ld_out_valid`) or `ld_out_ready`. A stalled load result holds its value unchanged.
- R9: After reset both output valids are low, and the next accepted load beat is treated as the first beat of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_in_valid | input | 1 | Store request valid |
| st_in_ready | output | 1 | Store request accepted when high with valid |
| st_in_data | input | 64 | Store register value |
| st_in_ofs | input | 3 | Byte offset within the doubleword |
| st_in_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| st_in_rev | input | 1 | Byte-reverse the access |
| st_out_valid | output | 1 | Formatted store valid |
| st_out_ready | input | 1 | Downstream takes the formatted store |
| st_out_data | output | 64 | Lane-arranged store data for both requests |
| st_out_be_lo | output | 8 | Byte enables, first doubleword |
| st_out_be_hi | output | 8 | Byte enables, second doubleword |
| st_out_cross | output | 1 | Access needs a second doubleword |
| ld_in_valid | input | 1 | Returned doubleword beat valid |
| ld_in_ready | output | 1 | Beat accepted when high with valid |
| ld_in_data | input | 64 | Returned doubleword |
| ld_in_ofs | input | 3 | Byte offset (first beat only) |
| ld_in_size | input | 2 | Size code (first beat only) |
| ld_in_rev | input | 1 | Byte-reverse (first beat only) |
| ld_in_sext | input | 1 | Sign-extend (first beat only) |
| ld_out_valid | output | 1 | Register value valid |
| ld_out_ready | input | 1 | Consumer takes the register value |
| ld_out_data | output | 64 | Formatted register value |

## Verification
The bench builds the block with its default parameters: eight 8-bit lanes, so three offset bits and a two-bit size code. With these values, random stimulus reaches every combination of offset, size, reverse and sign flag. That includes the eight-byte access at offset 7, whose crossing moves seven of its bytes into the second doubleword. Long stretches with the output ready held mostly low keep results waiting in the output registers. During those stretches crossing loads arrive with control fields on their second beat that differ from the first.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

  typedef enum logic {
    SEQ_FIRST  = 1'b0,
    SEQ_SECOND = 1'b1
  } seq_e;

  // Select index for one byte of the lane crossbar.
  // to_mem=1: idx is a memory lane, result is the register byte feeding it.
  // to_mem=0: idx is a register byte, result is the memory lane feeding it.
  function automatic int lane_pick(input int idx, input int ofs, input int nbytes,
                                   input logic rev, input logic to_mem, input int lanes);
    int d;
    if (to_mem) begin
      d = (idx - ofs) & (lanes - 1);
      return rev ? ((nbytes - 1 - d) & (lanes - 1)) : d;
    end
    return rev ? ((ofs + nbytes - 1 - idx) & (lanes - 1)) : ((ofs + idx) & (lanes - 1));
  endfunction

endpackage

// File: rtl/lsf_mask.sv
module lsf_mask #(
  parameter int LANES = 8,
  parameter int OFS_W = 3,
  parameter int SZ_W  = 2
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [SZ_W-1:0]  size,
  output logic [LANES-1:0] mask_lo,
  output logic [LANES-1:0] mask_hi
);
  logic [LANES-1:0]   base;
  logic [2*LANES-1:0] wide;

  always_comb begin
    base = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < (1 << size)) base[i] = 1'b1;
    end
    wide = {{LANES{1'b0}}, base} << ofs;
  end

  assign mask_lo = wide[LANES-1:0];
  assign mask_hi = wide[2*LANES-1:LANES];
endmodule

// File: rtl/lsf_xbar.sv
module lsf_xbar #(
  parameter int   LANES  = 8,
  parameter int   LANE_W = 8,
  parameter int   OFS_W  = 3,
  parameter int   SZ_W   = 2,
  parameter logic TO_MEM = 1'b1
) (
  input  logic [LANES-1:0][LANE_W-1:0] din,
  input  logic [OFS_W-1:0]             ofs,
  input  logic [SZ_W-1:0]              size,
  input  logic                         rev,
  output logic [LANES-1:0][LANE_W-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [OFS_W-1:0] sel;
    always_comb begin
      sel = OFS_W'(lsf_pkg::lane_pick(g, int'(ofs), 1 << size, rev, TO_MEM, LANES));
      dout[g] = din[sel];
    end
  end
endmodule

// File: rtl/lsf_store_path.sv
module lsf_store_path #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int OFS_W  = 3,
  parameter int SZ_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [LANES-1:0][LANE_W-1:0] in_data,
  input  logic [OFS_W-1:0]             in_ofs,
  input  logic [SZ_W-1:0]              in_size,
  input  logic                         in_rev,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [LANES-1:0][LANE_W-1:0] out_data,
  output logic [LANES-1:0]             out_be_lo,
  output logic [LANES-1:0]             out_be_hi,
  output logic                         out_cross
);
  logic [LANES-1:0][LANE_W-1:0] lanes_w;
  logic [LANES-1:0]             m_lo, m_hi;
  logic                         take;

  lsf_mask #(.LANES(LANES), .OFS_W(OFS_W), .SZ_W(SZ_W)) u_mask (
    .ofs(in_ofs), .size(in_size), .mask_lo(m_lo), .mask_hi(m_hi)
  );

  lsf_xbar #(.LANES(LANES), .LANE_W(LANE_W), .OFS_W(OFS_W), .SZ_W(SZ_W), .TO_MEM(1'b1)) u_xbar (
    .din(in_data), .ofs(in_ofs), .size(in_size), .rev(in_rev), .dout(lanes_w)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_be_lo <= '0;
      out_be_hi <= '0;
      out_cross <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= lanes_w;
      out_be_lo <= m_lo;
      out_be_hi <= m_hi;
      out_cross <= |m_hi;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lsf_load_path.sv
module lsf_load_path #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int OFS_W  = 3,
  parameter int SZ_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [LANES-1:0][LANE_W-1:0] in_data,
  input  logic [OFS_W-1:0]             in_ofs,
  input  logic [SZ_W-1:0]              in_size,
  input  logic                         in_rev,
  input  logic                         in_sext,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [LANES-1:0][LANE_W-1:0] out_data
);
  import lsf_pkg::*;

  seq_e                         seq_q;
  logic [LANES-1:0][LANE_W-1:0] hold_q;
  logic [OFS_W-1:0]             h_ofs;
  logic [SZ_W-1:0]              h_size;
  logic                         h_rev, h_sext;

  logic [OFS_W-1:0]             u_ofs;
  logic [SZ_W-1:0]              u_size;
  logic                         u_rev, u_sext;
  logic [LANES-1:0]             m_lo, m_hi;
  logic [LANES-1:0][LANE_W-1:0] merged, perm, result;
  logic                         crosses, take, finish, sign_b;

  // Second beat uses the control captured with the first beat.
  always_comb begin
    if (seq_q == SEQ_SECOND) begin
      u_ofs = h_ofs; u_size = h_size; u_rev = h_rev; u_sext = h_sext;
    end else begin
      u_ofs = in_ofs; u_size = in_size; u_rev = in_rev; u_sext = in_sext;
    end
  end

  lsf_mask #(.LANES(LANES), .OFS_W(OFS_W), .SZ_W(SZ_W)) u_mask (
    .ofs(u_ofs), .size(u_size), .mask_lo(m_lo), .mask_hi(m_hi)
  );

  assign crosses = |m_hi;

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g] = (seq_q == SEQ_SECOND && !m_hi[g]) ? hold_q[g] : in_data[g];
  end

  lsf_xbar #(.LANES(LANES), .LANE_W(LANE_W), .OFS_W(OFS_W), .SZ_W(SZ_W), .TO_MEM(1'b0)) u_xbar (
    .din(merged), .ofs(u_ofs), .size(u_size), .rev(u_rev), .dout(perm)
  );

  always_comb begin
    sign_b = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (k == (1 << u_size) - 1) sign_b = perm[k][LANE_W-1];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_ext
    assign result[g] = (g < (1 << u_size)) ? perm[g]
                     : {LANE_W{u_sext & sign_b}};
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign finish   = take && (seq_q == SEQ_SECOND || !crosses);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q  <= SEQ_FIRST;
      hold_q <= '0;
      h_ofs  <= '0;
      h_size <= '0;
      h_rev  <= 1'b0;
      h_sext <= 1'b0;
    end else if (take) begin
      if (seq_q == SEQ_FIRST && crosses) begin
        seq_q  <= SEQ_SECOND;
        hold_q <= in_data;
        h_ofs  <= in_ofs;
        h_size <= in_size;
        h_rev  <= in_rev;
        h_sext <= in_sext;
      end else begin
        seq_q <= SEQ_FIRST;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (finish) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lsf_top.sv
module lsf_top #(
  parameter  int LANES  = 8,
  parameter  int LANE_W = 8,
  localparam int DW     = LANES * LANE_W,
  localparam int OFS_W  = $clog2(LANES),
  localparam int SZ_W   = $clog2(OFS_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_in_valid,
  output logic             st_in_ready,
  input  logic [DW-1:0]    st_in_data,
  input  logic [OFS_W-1:0] st_in_ofs,
  input  logic [SZ_W-1:0]  st_in_size,
  input  logic             st_in_rev,
  output logic             st_out_valid,
  input  logic             st_out_ready,
  output logic [DW-1:0]    st_out_data,
  output logic [LANES-1:0] st_out_be_lo,
  output logic [LANES-1:0] st_out_be_hi,
  output logic             st_out_cross,
  input  logic             ld_in_valid,
  output logic             ld_in_ready,
  input  logic [DW-1:0]    ld_in_data,
  input  logic [OFS_W-1:0] ld_in_ofs,
  input  logic [SZ_W-1:0]  ld_in_size,
  input  logic             ld_in_rev,
  input  logic             ld_in_sext,
  output logic             ld_out_valid,
  input  logic             ld_out_ready,
  output logic [DW-1:0]    ld_out_data
);
  logic [LANES-1:0][LANE_W-1:0] st_in_l, st_out_l, ld_in_l, ld_out_l;

  assign st_in_l     = st_in_data;
  assign st_out_data = st_out_l;
  assign ld_in_l     = ld_in_data;
  assign ld_out_data = ld_out_l;

  lsf_store_path #(.LANES(LANES), .LANE_W(LANE_W), .OFS_W(OFS_W), .SZ_W(SZ_W)) u_st (
    .clk(clk), .rst_n(rst_n),
    .in_valid(st_in_valid), .in_ready(st_in_ready), .in_data(st_in_l),
    .in_ofs(st_in_ofs), .in_size(st_in_size), .in_rev(st_in_rev),
    .out_valid(st_out_valid), .out_ready(st_out_ready), .out_data(st_out_l),
    .out_be_lo(st_out_be_lo), .out_be_hi(st_out_be_hi), .out_cross(st_out_cross)
  );

  lsf_load_path #(.LANES(LANES), .LANE_W(LANE_W), .OFS_W(OFS_W), .SZ_W(SZ_W)) u_ld (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ld_in_valid), .in_ready(ld_in_ready), .in_data(ld_in_l),
    .in_ofs(ld_in_ofs), .in_size(ld_in_size), .in_rev(ld_in_rev), .in_sext(ld_in_sext),
    .out_valid(ld_out_valid), .out_ready(ld_out_ready), .out_data(ld_out_l)
  );
endmodule

// File: rtl/lsf_chk.sv
module lsf_chk #(
  parameter  int LANES  = 8,
  parameter  int LANE_W = 8,
  localparam int DW     = LANES * LANE_W,
  localparam int OFS_W  = $clog2(LANES),
  localparam int SZ_W   = $clog2(OFS_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_in_valid,
  input logic             st_in_ready,
  input logic [DW-1:0]    st_in_data,
  input logic [OFS_W-1:0] st_in_ofs,
  input logic [SZ_W-1:0]  st_in_size,
  input logic             st_in_rev,
  input logic             st_out_valid,
  input logic             st_out_ready,
  input logic [DW-1:0]    st_out_data,
  input logic [LANES-1:0] st_out_be_lo,
  input logic [LANES-1:0] st_out_be_hi,
  input logic             st_out_cross,
  input logic             ld_in_valid,
  input logic             ld_in_ready,
  input logic [DW-1:0]    ld_in_data,
  input logic [OFS_W-1:0] ld_in_ofs,
  input logic [SZ_W-1:0]  ld_in_size,
  input logic             ld_in_rev,
  input logic             ld_in_sext,
  input logic             ld_out_valid,
  input logic             ld_out_ready,
  input logic [DW-1:0]    ld_out_data
);
  p_st_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_out_valid && !st_out_ready |=> st_out_valid && $stable(st_out_data)
      && $stable(st_out_be_lo) && $stable(st_out_be_hi) && $stable(st_out_cross));

  p_ld_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_out_valid && !ld_out_ready |=> ld_out_valid && $stable(ld_out_data));

  p_be_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_out_valid |-> $onehot($countones({st_out_be_hi, st_out_be_lo})));

  p_cross_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_out_valid && st_out_cross |-> st_out_be_lo[LANES-1] && st_out_be_hi[0]);

  p_st_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_out_valid) |-> $past(st_in_valid && st_in_ready));

  p_ld_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_out_valid) |-> $past(ld_in_valid && ld_in_ready));
endmodule

bind lsf_top lsf_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_lsf_top.sv
`timescale 1ns/1ps
module sim_lsf_top;
  localparam real CYC = 20.0;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        st_in_valid = 0, st_in_ready, st_in_rev = 0, st_out_valid, st_out_ready = 0, st_out_cross;
  logic [63:0] st_in_data = '0, st_out_data;
  logic [2:0]  st_in_ofs = '0;
  logic [1:0]  st_in_size = '0;
  logic [7:0]  st_out_be_lo, st_out_be_hi;
  logic        ld_in_valid = 0, ld_in_ready, ld_in_rev = 0, ld_in_sext = 0, ld_out_valid, ld_out_ready = 0;
  logic [63:0] ld_in_data = '0, ld_out_data;
  logic [2:0]  ld_in_ofs = '0;
  logic [1:0]  ld_in_size = '0;

  always #(CYC/2) clk = ~clk;

  lsf_top u0 (.*);

  int n_chk = 0, n_fail = 0;

  // reference model state
  bit          ms_v = 0, ms_x = 0;
  logic [63:0] ms_d = '0;
  logic [7:0]  ms_lo = '0, ms_hi = '0;
  string       ms_tag = "R1";
  bit          ml_v = 0, ml_pend = 0;
  logic [63:0] ml_d = '0, ml_hold = '0;
  string       ml_tag = "R4";
  int          h_ofs, h_n;
  bit          h_rev, h_sext;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [63:0] st_ref(input logic [63:0] d, input int o, input int n, input bit rv);
    logic [63:0] r;
    for (int L = 0; L < 8; L++) begin
      int k = (L - o + 8) % 8;
      int s = rv ? ((n - 1 - k + 8) % 8) : k;
      r[L*8 +: 8] = d[s*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [15:0] mask_ref(input int o, input int n);
    logic [15:0] m = (16'd1 << n) - 16'd1;
    return m << o;
  endfunction

  function automatic logic [63:0] ld_ref(input logic [63:0] mem, input int o, input int n, input bit rv, input bit sx);
    logic [63:0] r;
    logic        sb;
    for (int k = 0; k < n; k++) begin
      int L = rv ? ((o + n - 1 - k) % 8) : ((o + k) % 8);
      r[k*8 +: 8] = mem[L*8 +: 8];
    end
    sb = r[(n-1)*8 + 7];
    for (int k = n; k < 8; k++) r[k*8 +: 8] = (sx && sb) ? 8'hFF : 8'h00;
    return r;
  endfunction

  task automatic compare();
    chk(st_out_valid == ms_v, "R7 st_valid", 64'(st_out_valid), 64'(ms_v));
    if (ms_v && st_out_valid) begin
      chk(st_out_data == ms_d, ms_tag, st_out_data, ms_d);
      chk({st_out_be_hi, st_out_be_lo} == {ms_hi, ms_lo}, "R3 masks",
          64'({st_out_be_hi, st_out_be_lo}), 64'({ms_hi, ms_lo}));
      chk(st_out_cross == ms_x, "R3 cross", 64'(st_out_cross), 64'(ms_x));
    end
    chk(ld_out_valid == ml_v, "R8 ld_valid", 64'(ld_out_valid), 64'(ml_v));
    if (ml_v && ld_out_valid) chk(ld_out_data == ml_d, ml_tag, ld_out_data, ml_d);
  endtask

  task automatic step(input int rdy_pct);
    bit st_fire, ld_fire;
    @(negedge clk);
    compare();
    st_in_valid  = ($urandom % 100) < 70;
    st_in_data   = {$urandom, $urandom};
    st_in_ofs    = 3'($urandom);
    st_in_size   = 2'($urandom);
    st_in_rev    = 1'($urandom);
    st_out_ready = ($urandom % 100) < rdy_pct;
    ld_in_valid  = ($urandom % 100) < 70;
    ld_in_data   = {$urandom, $urandom};
    ld_in_ofs    = 3'($urandom);
    ld_in_size   = 2'($urandom);
    ld_in_rev    = 1'($urandom);
    ld_in_sext   = 1'($urandom);
    ld_out_ready = ($urandom % 100) < rdy_pct;
    #1;
    chk(st_in_ready == (!ms_v || st_out_ready), "R7 st_in_ready", 64'(st_in_ready), 64'(!ms_v || st_out_ready));
    chk(ld_in_ready == (!ml_v || ld_out_ready), "R8 ld_in_ready", 64'(ld_in_ready), 64'(!ml_v || ld_out_ready));
    st_fire = st_in_valid && st_in_ready;
    ld_fire = ld_in_valid && ld_in_ready;
    // store model
    if (st_fire) begin
      int n = 1 << st_in_size;
      logic [15:0] m = mask_ref(st_in_ofs, n);
      ms_v = 1; ms_d = st_ref(st_in_data, st_in_ofs, n, st_in_rev);
      ms_lo = m[7:0]; ms_hi = m[15:8]; ms_x = (m[15:8] != 0);
      ms_tag = st_in_rev ? "R2 st_data" : "R1 st_data";
    end else if (ms_v && st_out_ready) ms_v = 0;
    // load model
    if (ld_fire) begin
      if (!ml_pend) begin
        int n = 1 << ld_in_size;
        if (ld_in_ofs + n > 8) begin
          ml_pend = 1; ml_hold = ld_in_data;
          h_ofs = ld_in_ofs; h_n = n; h_rev = ld_in_rev; h_sext = ld_in_sext;
          if (ml_v && ld_out_ready) ml_v = 0;
        end else begin
          ml_v = 1; ml_d = ld_ref(ld_in_data, ld_in_ofs, n, ld_in_rev, ld_in_sext);
          ml_tag = (n < 8) ? "R5 ld_data" : "R4 ld_data";
        end
      end else begin
        logic [15:0] m = mask_ref(h_ofs, h_n);
        logic [63:0] mem;
        for (int L = 0; L < 8; L++) mem[L*8 +: 8] = m[8+L] ? ld_in_data[L*8 +: 8] : ml_hold[L*8 +: 8];
        ml_pend = 0; ml_v = 1;
        ml_d = ld_ref(mem, h_ofs, h_n, h_rev, h_sext);
        ml_tag = "R6 ld_cross";
      end
    end else if (ml_v && ld_out_ready) ml_v = 0;
  endtask

  initial begin
    #(CYC * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs idle under reset
    chk(st_out_valid == 0, "R9 st_valid reset", 64'(st_out_valid), 64'd0);
    chk(ld_out_valid == 0, "R9 ld_valid reset", 64'(ld_out_valid), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 4000; i++) step(70);
    for (int i = 0; i < 2000; i++) step(15);
    for (int i = 0; i < 2000; i++) step(100);
    finish_run();
  end
endmodule